// File: doc/BRIEF.md
# Quad Serial Erase Command Master

This controller sits on the host side of a serial flash. The flash has a 4-bit data bus. A caller hands it one erase job, which is either a single block at a 24-bit address or the whole array. The controller then drives the chip-select, serial clock and data lines to carry out the full erase exchange. Every byte goes out as two nibbles, with the high nibble first. The serial clock runs at half the system clock rate. Data changes while the clock is low, and the clock rests low whenever the select line is inactive.

Each job runs as a series of separate framed commands:
- a write-enable byte;
- the erase opcode, followed by three address bytes for a block erase;
- a completion wait.

The wait can be done in one of two ways, chosen by a parameter. In the first, the controller repeatedly reads the status byte until its busy flag is clear. In the second, it counts a fixed, per-type number of cycles. Between any two commands the select line stays inactive for a parameterised minimum time. A job is accepted only while the controller reports that it is ready. When the job finishes, the controller raises a single-cycle completion pulse.

Top module: `qspi_erase_master`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low, ready is high and done is low.
- R2: Every accepted job first sends opcode 06h alone, in a frame of its own, as two nibbles.
- R3: A block job sends opcode D8h, then the 24-bit address from its most significant bit down, for 8 nibbles in one frame. Each nibble is the high half of its byte before the low half, and data is stable while the clock is high.
- R4: A full-array job sends opcode C7h with no address, for exactly 2 nibbles in one frame.
- R5: Between two frames, chip select stays high for at least CS_GAP cycles, and the serial clock never goes high while chip select is high.
- R6: When POLL_MODE is 1, each poll is a frame made of opcode 05h followed by two nibbles read from the flash. The upper nibble is read first. Busy is bit 0 of the status byte, which is bit 0 of the second nibble read. Polling frames repeat while busy reads 1.
- R7: done is high for exactly one cycle per job. It comes only after the last frame has ended, and ready is high in the same cycle.
- R8: A request made while ready is low has no effect: it produces no extra frame and no extra done pulse.
- R9: When POLL_MODE is 0, no status frames are sent. done rises exactly BLK_WAIT cycles (block job) or CHIP_WAIT cycles (full-array job) after chip select rises at the end of the erase frame.
- R10: The data output enable is high for every nibble the controller drives, and low for the two status nibbles it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Job request, sampled while ready is high |
| req_chip | input | 1 | 1 selects full-array erase, 0 a block erase |
| req_addr | input | 24 | Block address for a block erase |
| req_ready | output | 1 | High when a new job can be accepted |
| done | output | 1 | One-cycle completion pulse |
| fl_cs_n | output | 1 | Active-low flash select |
| fl_sck | output | 1 | Serial clock, idles low |
| fl_dout | output | 4 | Nibble driven to the flash |
| fl_oe | output | 1 | High while fl_dout should drive the bus |
| fl_din | input | 4 | Nibble returned by the flash |

## Verification
The bench uses two instances of the controller.

The polling instance uses a select gap of 4 cycles. It is driven against a flash model whose busy flag stays set for 0, 1, 2 or 5 polls. The status byte it returns carries set bits around bit 0, so only the correct flag bit ends a job.

The timed instance has polling switched off, a select gap of 2, and wait counts of 37 and 90. These short counts make the exact cycle distance from the end of the erase frame to done measurable for both job types in a short run.

// File: rtl/qspi_erase_master.sv
module qspi_erase_master #(
  parameter int CS_GAP    = 4,
  parameter int POLL_MODE = 1,
  parameter int BLK_WAIT  = 1000,
  parameter int CHIP_WAIT = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_chip,
  input  logic [23:0] req_addr,
  output logic        req_ready,
  output logic        done,
  output logic        fl_cs_n,
  output logic        fl_sck,
  output logic [3:0]  fl_dout,
  output logic        fl_oe,
  input  logic [3:0]  fl_din
);
  localparam int MAXW = (BLK_WAIT > CHIP_WAIT) ? BLK_WAIT : CHIP_WAIT;
  localparam int GW   = $clog2(CS_GAP + 1);
  localparam int WW   = $clog2(MAXW + 1);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_BLK  = 8'hD8;
  localparam logic [7:0] OP_CHIP = 8'hC7;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_TX, S_RX, S_WAIT} st_t;
  typedef enum logic [1:0] {K_WREN, K_ERASE, K_POLL} stp_t;

  st_t         st;
  stp_t        stp;
  logic [31:0] sh;
  logic [3:0]  nib;
  logic        ph;
  logic [GW-1:0] gap;
  logic [WW-1:0] tmr;
  logic        chip_q;
  logic [23:0] addr_q;
  logic        done_q;
  logic [WW-1:0] wait_last;

  assign wait_last = chip_q ? WW'(CHIP_WAIT - 1) : WW'(BLK_WAIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      stp    <= K_WREN;
      sh     <= '0;
      nib    <= '0;
      ph     <= 1'b0;
      gap    <= '0;
      tmr    <= '0;
      chip_q <= 1'b0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            chip_q <= req_chip;
            addr_q <= req_addr;
            stp    <= K_WREN;
            gap    <= '0;
            st     <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap == GW'(CS_GAP - 1)) begin
            st <= S_TX;
            ph <= 1'b0;
            case (stp)
              K_WREN: begin
                sh  <= {OP_WREN, 24'h0};
                nib <= 4'd2;
              end
              K_ERASE: begin
                sh  <= chip_q ? {OP_CHIP, 24'h0} : {OP_BLK, addr_q};
                nib <= chip_q ? 4'd2 : 4'd8;
              end
              default: begin
                sh  <= {OP_RDSR, 24'h0};
                nib <= 4'd2;
              end
            endcase
          end else begin
            gap <= gap + 1'b1;
          end
        end
        S_TX: begin
          ph <= ~ph;
          if (ph) begin
            sh  <= {sh[27:0], 4'h0};
            nib <= nib - 1'b1;
            if (nib == 4'd1) begin
              gap <= '0;
              case (stp)
                K_WREN: begin
                  stp <= K_ERASE;
                  st  <= S_GAP;
                end
                K_ERASE: begin
                  if (POLL_MODE != 0) begin
                    stp <= K_POLL;
                    st  <= S_GAP;
                  end else begin
                    tmr <= '0;
                    st  <= S_WAIT;
                  end
                end
                default: begin
                  nib <= 4'd2;
                  st  <= S_RX;
                end
              endcase
            end
          end
        end
        S_RX: begin
          ph <= ~ph;
          if (ph) begin
            nib <= nib - 1'b1;
            if (nib == 4'd1) begin
              gap <= '0;
              if (fl_din[0]) begin
                st <= S_GAP;
              end else begin
                st     <= S_IDLE;
                done_q <= 1'b1;
              end
            end
          end
        end
        S_WAIT: begin
          if (tmr == wait_last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fl_cs_n   = !(st == S_TX || st == S_RX);
  assign fl_sck    = !fl_cs_n && ph;
  assign fl_dout   = (st == S_TX) ? sh[31:28] : 4'h0;
  assign fl_oe     = (st == S_TX);
  assign req_ready = (st == S_IDLE);
  assign done      = done_q;

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck);

  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CS_GAP > 1 && $rose(fl_cs_n)) |=> fl_cs_n);

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_sck |-> $stable(fl_dout));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && fl_cs_n));

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_oe |-> !fl_cs_n);

  // R9
  no_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (POLL_MODE == 0) |-> fl_oe || fl_cs_n);
endmodule

// File: tb/qspi_erase_master_tb.sv
module qspi_erase_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_I = 4;
  localparam int GAP_W = 2;
  localparam int BW = 37;
  localparam int CW = 90;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic req_valid = 1'b0, req_chip = 1'b0, vw = 1'b0;
  logic [23:0] req_addr = '0;
  logic rdy, done, cs_n, sck, oe;
  logic [3:0] dout, din;
  logic rdy_w, done_w, cs_w, sck_w, oe_w;
  logic [3:0] dout_w;

  qspi_erase_master #(.CS_GAP(GAP_I), .POLL_MODE(1), .BLK_WAIT(8), .CHIP_WAIT(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(req_chip), .req_addr(req_addr),
    .req_ready(rdy), .done(done), .fl_cs_n(cs_n), .fl_sck(sck), .fl_dout(dout), .fl_oe(oe),
    .fl_din(din));

  qspi_erase_master #(.CS_GAP(GAP_W), .POLL_MODE(0), .BLK_WAIT(BW), .CHIP_WAIT(CW)) dut_w (
    .clk(clk), .rst_n(rst_n), .req_valid(vw), .req_chip(req_chip), .req_addr(req_addr),
    .req_ready(rdy_w), .done(done_w), .fl_cs_n(cs_w), .fl_sck(sck_w), .fl_dout(dout_w),
    .fl_oe(oe_w), .fl_din(4'hF));

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [3:0]  nibs;
  } item_t;
  item_t exq[$];

  int nib_idx = 0, busy_left = 0, busy_cfg = 0, hi_cnt = 0, done_cnt = 0;
  logic [31:0] acc = '0;
  logic [7:0] op_r = '0;
  logic prev_cs = 1'b1, prev_sck = 1'b0, prev_done = 1'b0, bad_idle = 1'b0;

  assign din = (nib_idx == 3) ? 4'hE : {3'b101, busy_left != 0};

  always @(negedge clk) if (rst_n) begin
    if (!cs_n && sck && !prev_sck) begin
      chk(oe == !(nib_idx >= 2 && op_r == 8'h05), "R10", "output enable", oe,
          !(nib_idx >= 2 && op_r == 8'h05));
      if (nib_idx < 8) acc = {acc[27:0], dout};
      if (nib_idx == 1) op_r = acc[7:0];
      nib_idx++;
    end
    if (cs_n && sck) bad_idle = 1'b1;
    if (cs_n && !prev_cs) begin
      if (exq.size() == 0) begin
        chk(0, "R8", "unexpected frame opcode", op_r, 0);
      end else begin
        item_t it;
        string rq;
        it = exq.pop_front();
        rq = (it.op == 8'h06) ? "R2" : (it.op == 8'hD8) ? "R3" : (it.op == 8'hC7) ? "R4" : "R6";
        chk(op_r == it.op, rq, "opcode", op_r, it.op);
        chk(nib_idx == int'(it.nibs), rq, "nibble count", nib_idx, it.nibs);
        if (it.op == 8'hD8) chk(acc[23:0] == it.addr, "R3", "address", acc[23:0], it.addr);
      end
      if (op_r == 8'hD8 || op_r == 8'hC7) busy_left = busy_cfg;
      else if (op_r == 8'h05 && busy_left > 0) busy_left--;
      nib_idx = 0;
      acc = '0;
      op_r = '0;
    end
    if (!cs_n && prev_cs) chk(hi_cnt >= GAP_I, "R5", "select high time", hi_cnt, GAP_I);
    hi_cnt = cs_n ? hi_cnt + 1 : 0;
    if (done) begin
      done_cnt++;
      chk(exq.size() == 0, "R7", "frames pending at done", exq.size(), 0);
      chk(rdy, "R7", "ready with done", rdy, 1);
      if (prev_done) chk(0, "R7", "done wider than one cycle", 2, 1);
    end
    prev_cs = cs_n;
    prev_sck = sck;
    prev_done = done;
  end

  int rise_w = 0, wcnt = 0, wexp = 0, wdone = 0;
  bit wrun = 0;
  logic prev_cs_w = 1'b1;

  always @(negedge clk) if (rst_n) begin
    if (cs_w && !prev_cs_w) begin
      rise_w++;
      if (rise_w == 2) begin
        wcnt = 0;
        wrun = 1;
      end
    end else if (wrun) begin
      wcnt++;
    end
    if (done_w) begin
      chk(wrun && wcnt == wexp, "R9", "cycles from erase frame end to done", wcnt, wexp);
      wrun = 0;
      wdone++;
    end
    prev_cs_w = cs_w;
  end

  task automatic erase_i(input bit chip, input logic [23:0] addr, input int polls,
                         input bit poke);
    int start;
    busy_cfg = polls;
    exq.push_back('{op: 8'h06, addr: 24'h0, nibs: 4'd2});
    if (chip) exq.push_back('{op: 8'hC7, addr: 24'h0, nibs: 4'd2});
    else      exq.push_back('{op: 8'hD8, addr: addr, nibs: 4'd8});
    for (int k = 0; k <= polls; k++) exq.push_back('{op: 8'h05, addr: 24'h0, nibs: 4'd4});
    while (!rdy) @(negedge clk);
    start = done_cnt;
    req_valid = 1'b1;
    req_chip = chip;
    req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      req_valid = 1'b1;
      req_chip = 1'b1;
      req_addr = 24'h123456;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == start) @(negedge clk);
    chk(done_cnt == start + 1, "R7", "done count per job", done_cnt - start, 1);
  endtask

  task automatic erase_w(input bit chip, input logic [23:0] addr, input int w);
    int start;
    rise_w = 0;
    wexp = w;
    start = wdone;
    while (!rdy_w) @(negedge clk);
    vw = 1'b1;
    req_chip = chip;
    req_addr = addr;
    @(negedge clk);
    vw = 1'b0;
    while (wdone == start) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(rise_w == 2, "R9", "frames without polling", rise_w, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "select in reset", cs_n, 1);
    chk(sck == 1'b0, "R1", "clock in reset", sck, 0);
    chk(rdy == 1'b1, "R1", "ready in reset", rdy, 1);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(cs_w == 1'b1 && done_w == 1'b0, "R1", "timed instance in reset", {cs_w, done_w}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    erase_i(1'b0, 24'h3A5C7E, 2, 1'b0);
    erase_i(1'b1, 24'h000000, 0, 1'b0);
    erase_i(1'b0, 24'hFFFFFF, 5, 1'b1);
    repeat (100) @(negedge clk);
    // R8 the request raised mid-job left no trace
    chk(cs_n && hi_cnt >= 100, "R8", "idle after ignored request", hi_cnt, 100);
    chk(exq.size() == 0, "R8", "queue drained", exq.size(), 0);
    chk(done_cnt == 3, "R8", "done pulses", done_cnt, 3);
    erase_i(1'b0, 24'h000001, 1, 1'b0);
    chk(!bad_idle, "R5", "clock high while deselected", bad_idle, 0);
    erase_w(1'b0, 24'h00ABCD, BW);
    erase_w(1'b1, 24'h000000, CW);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule